// File: doc/BRIEF.md
# Frequency-Ranked Victim Selector With Recency Tiebreak

This block holds the replacement bookkeeping for every way of a single cache set and names the way to evict when the set misses. Each way keeps a saturating use counter and a last-access stamp. The stamp is copied from a free-running time base inside the block. The caller raises per-way strobes for invalidation, for hits and for line installs. When it needs a victim, it raises a request.

The victim is the way with the fewest recorded uses. When several ways share that lowest count, the one touched longest ago wins. When both count and stamp are equal, the lowest-numbered way wins. Invalid ways have a stamp of zero, so they are preferred over valid lines with the same count. Tag lookup, data storage and set indexing stay with the caller. The caller replicates the block per set or wraps it with indexed storage.

Top module: `lfu_victim_sel`

## Requirements
- R1: An invalidate strobe on a way clears that way's use count and its stamp to zero.
- R2: A hit strobe on a way adds one to its use count and loads the current time into its stamp.
- R3: A fill strobe on a way sets its use count to exactly one and loads the current time into its stamp.
- R4: The selected victim has the smallest use count of all ways.
- R5: Among ways sharing the smallest count, the one with the smallest stamp (oldest access) is selected.
- R6: When both count and stamp are tied, the lowest way index is selected.
- R7: `victim_vld_o` is high in exactly the cycle after a cycle with `victim_req_i` high, and low otherwise. `victim_way_o` then holds the binary way index computed from the state present when the request was sampled.
- R8: For one way in one cycle, invalidate overrides fill, and fill overrides hit.
- R9: A use count held at its maximum value (2^CNT_W − 1) stays there on further hits instead of wrapping.
- R10: After reset, every way has count and stamp zero, and `victim_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inval_i | input | WAYS | Per-way invalidate strobe |
| touch_i | input | WAYS | Per-way hit strobe |
| fill_i | input | WAYS | Per-way install strobe |
| victim_req_i | input | 1 | Request a victim decision |
| victim_way_o | output | IDX_W | Registered victim way index |
| victim_vld_o | output | 1 | Victim index valid, one cycle after request |

## Verification
Several rules are checked on every cycle by the assertions:
- the per-way update rules for invalidate, install and hit;
- the saturation hold;
- the one-cycle request-to-valid relation;
- whether the scanned victim has a minimal count and, among equal counts, a minimal stamp.

Other behaviour shows up only in the bench's scenarios: the ordering of stamps across successive accesses, the lowest-index outcome of a full tie, and the priority of simultaneous strobes. There the victim choice differs depending on which update took effect, or on whether the counter wrapped.

// File: rtl/lfu_pkg.sv
package lfu_pkg;

   typedef enum logic [1:0] {
      WAY_HOLD  = 2'd0,
      WAY_CLEAR = 2'd1,
      WAY_LOAD  = 2'd2,
      WAY_BUMP  = 2'd3
   } way_op_e;

   // Priority: clear over load over bump (R8)
   function automatic way_op_e decode_op(input logic inv, input logic fil, input logic tch);
      if (inv)      return WAY_CLEAR;
      else if (fil) return WAY_LOAD;
      else if (tch) return WAY_BUMP;
      else          return WAY_HOLD;
   endfunction

endpackage

// File: rtl/lfu_time_base.sv
module lfu_time_base #(
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [TIME_W-1:0] now_o
);
   localparam logic [TIME_W-1:0] TIME_MAX = '1;

   // Starts at one so a stamped way never looks invalid; holds at the top
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                now_o <= TIME_W'(1);
      else if (now_o != TIME_MAX) now_o <= now_o + TIME_W'(1);
   end
endmodule

// File: rtl/lfu_way_state.sv
module lfu_way_state
   import lfu_pkg::*;
#(
   parameter int CNT_W  = 3,
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inval_i,
   input  logic              touch_i,
   input  logic              fill_i,
   input  logic [TIME_W-1:0] now_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [TIME_W-1:0] stamp_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   way_op_e op;
   assign op = decode_op(inval_i, fill_i, touch_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o   <= '0;
         stamp_o <= '0;
      end else begin
         unique case (op)
            WAY_CLEAR: begin
               cnt_o   <= '0;
               stamp_o <= '0;
            end
            WAY_LOAD: begin
               cnt_o   <= CNT_W'(1);
               stamp_o <= now_i;
            end
            WAY_BUMP: begin
               if (cnt_o != CNT_MAX) cnt_o <= cnt_o + CNT_W'(1);
               stamp_o <= now_i;
            end
            default: ;
         endcase
      end
   end

   assert_inval_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      inval_i |=> (cnt_o == '0 && stamp_o == '0));

   assert_touch_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_i && !fill_i && !inval_i && cnt_o != CNT_MAX) |=>
         (cnt_o == $past(cnt_o) + CNT_W'(1) && stamp_o == $past(now_i)));

   assert_fill_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_i && !inval_i) |=> (cnt_o == CNT_W'(1) && stamp_o == $past(now_i)));

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o == CNT_MAX && touch_i && !fill_i && !inval_i) |=> cnt_o == CNT_MAX);
endmodule

// File: rtl/lfu_victim_scan.sv
module lfu_victim_scan #(
   parameter int WAYS   = 4,
   parameter int CNT_W  = 3,
   parameter int TIME_W = 16,
   localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0][CNT_W-1:0]  cnt_i,
   input  logic [WAYS-1:0][TIME_W-1:0] stamp_i,
   output logic [IDX_W-1:0]            victim_o
);
   logic [CNT_W-1:0]  best_cnt;
   logic [TIME_W-1:0] best_ts;

   // Way 0 is provisional; replaced only on strictly better (R4, R5, R6)
   always_comb begin
      victim_o = '0;
      best_cnt = cnt_i[0];
      best_ts  = stamp_i[0];
      for (int i = 1; i < WAYS; i++) begin
         if ((cnt_i[i] < best_cnt) ||
             (cnt_i[i] == best_cnt && stamp_i[i] < best_ts)) begin
            victim_o = IDX_W'(i);
            best_cnt = cnt_i[i];
            best_ts  = stamp_i[i];
         end
      end
   end

   always_comb begin
      for (int k = 0; k < WAYS; k++) begin
         assert_min_count_R4: assert (cnt_i[victim_o] <= cnt_i[k]);
         assert_oldest_tie_R5: assert (cnt_i[victim_o] != cnt_i[k] ||
                                       stamp_i[victim_o] <= stamp_i[k]);
      end
   end
endmodule

// File: rtl/lfu_victim_sel.sv
module lfu_victim_sel #(
   parameter int WAYS   = 4,
   parameter int CNT_W  = 3,
   parameter int TIME_W = 16,
   localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WAYS-1:0]  inval_i,
   input  logic [WAYS-1:0]  touch_i,
   input  logic [WAYS-1:0]  fill_i,
   input  logic             victim_req_i,
   output logic [IDX_W-1:0] victim_way_o,
   output logic             victim_vld_o
);
   if (WAYS < 2)   begin : g_bad_ways  $error("WAYS must be at least 2");   end
   if (CNT_W < 2)  begin : g_bad_cnt   $error("CNT_W must be at least 2");  end
   if (TIME_W < 4) begin : g_bad_time  $error("TIME_W must be at least 4"); end

   logic [TIME_W-1:0]             now;
   logic [WAYS-1:0][CNT_W-1:0]    cnt_all;
   logic [WAYS-1:0][TIME_W-1:0]   stamp_all;
   logic [IDX_W-1:0]              scan_way;

   lfu_time_base #(.TIME_W(TIME_W)) u_time (
      .clk   (clk),
      .rst_n (rst_n),
      .now_o (now)
   );

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      lfu_way_state #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_state (
         .clk     (clk),
         .rst_n   (rst_n),
         .inval_i (inval_i[w]),
         .touch_i (touch_i[w]),
         .fill_i  (fill_i[w]),
         .now_i   (now),
         .cnt_o   (cnt_all[w]),
         .stamp_o (stamp_all[w])
      );
   end

   lfu_victim_scan #(.WAYS(WAYS), .CNT_W(CNT_W), .TIME_W(TIME_W)) u_scan (
      .cnt_i    (cnt_all),
      .stamp_i  (stamp_all),
      .victim_o (scan_way)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         victim_vld_o <= 1'b0;
         victim_way_o <= '0;
      end else begin
         victim_vld_o <= victim_req_i;
         if (victim_req_i) victim_way_o <= scan_way;
      end
   end

   assert_vld_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      victim_req_i |=> victim_vld_o);

   assert_vld_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !victim_req_i |=> !victim_vld_o);

   assert_way_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !victim_req_i |=> $stable(victim_way_o));
endmodule

// File: tb/lfu_victim_sel_bench.sv
module lfu_victim_sel_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WAYS = 4;
   localparam int NVEC = 14;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] inval = '0, touch = '0, fill = '0;
   logic       req = 1'b0;
   logic [1:0] vway;
   logic       vvld;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lfu_victim_sel #(.WAYS(WAYS), .CNT_W(3), .TIME_W(16)) u_lfu_victim_sel (
      .clk          (clk),
      .rst_n        (rst_n),
      .inval_i      (inval),
      .touch_i      (touch),
      .fill_i       (fill),
      .victim_req_i (req),
      .victim_way_o (vway),
      .victim_vld_o (vvld)
   );

   // {inval, touch, fill, req, expected victim}
   localparam logic [14:0] VEC [NVEC] = '{
      {4'b0000, 4'b0000, 4'b0001, 1'b0, 2'd0},
      {4'b0000, 4'b0000, 4'b0010, 1'b0, 2'd0},
      {4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd2},  // R6 empty ways 2,3 tie
      {4'b0000, 4'b0000, 4'b0100, 1'b0, 2'd0},
      {4'b0000, 4'b0000, 4'b1000, 1'b0, 2'd0},
      {4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd0},  // R3/R5 oldest install
      {4'b0000, 4'b0001, 4'b0000, 1'b0, 2'd0},
      {4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1},  // R2/R4 way0 raised
      {4'b0000, 4'b0010, 4'b0000, 1'b0, 2'd0},
      {4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd2},
      {4'b0000, 4'b1100, 4'b0000, 1'b0, 2'd0},
      {4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd0},  // R5 all count 2, way0 oldest
      {4'b0010, 4'b0000, 4'b0000, 1'b0, 2'd0},
      {4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1}   // R1 cleared way wins
   };

   task automatic check(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, observe at next falling edge
   task automatic step(input logic [3:0] iv, input logic [3:0] tc,
                       input logic [3:0] fl, input logic rq);
      inval = iv; touch = tc; fill = fl; req = rq;
      @(negedge clk);
      inval = '0; touch = '0; fill = '0; req = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();

      // R10: no valid after reset
      check(int'(vvld), 0, "R10 vld low after reset");
      step('0, '0, '0, 1'b1);
      check(int'(vvld), 1, "R7 vld one cycle after request");
      check(int'(vway), 0, "R10/R6 all-empty set picks way 0");
      @(negedge clk);
      check(int'(vvld), 0, "R7 vld drops without request");

      // Vector table walk
      for (int i = 0; i < NVEC; i++) begin
         logic [14:0] v;
         v = VEC[i];
         step(v[14:11], v[10:7], v[6:3], v[2]);
         if (v[2]) begin
            check(int'(vvld), 1, $sformatf("R7 vector %0d valid", i));
            check(int'(vway), int'(v[1:0]), $sformatf("R4/R5 vector %0d victim", i));
         end
      end

      // R8: fill beats touch on the same way
      do_reset();
      step('0, '0, 4'b1111, 1'b0);
      step('0, 4'b1111, '0, 1'b0);
      step('0, 4'b0001, '0, 1'b0);
      step('0, 4'b0001, 4'b0001, 1'b0);
      step('0, '0, '0, 1'b1);
      check(int'(vway), 0, "R8 fill overrides touch");

      // R8: invalidate beats fill
      step(4'b0010, '0, 4'b0010, 1'b0);
      step('0, '0, '0, 1'b1);
      check(int'(vway), 1, "R8 invalidate overrides fill");

      // R9: counter saturates (wrapping would make way 0 the victim)
      do_reset();
      step('0, '0, 4'b1111, 1'b0);
      step('0, 4'b1110, '0, 1'b0);
      step('0, 4'b1110, '0, 1'b0);
      for (int k = 0; k < 9; k++) step('0, 4'b0001, '0, 1'b0);
      step('0, '0, '0, 1'b1);
      check(int'(vway), 1, "R9 saturated count stays maximal");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule